// File: doc/BRIEF.md
# Fast System-Call Privilege Transition Unit

This block holds the architectural state changes that a CPU model needs for a fast kernel-entry instruction and for its matching return instruction. Three 64-bit model-specific registers configure it: the kernel code selector, the kernel entry stack pointer and the kernel entry instruction pointer. Software loads and reads them through a port indexed by the ECX value, with data carried as EDX:EAX. No descriptor is fetched. The code and stack selectors are derived by arithmetic from the one configured selector. The hidden segment attributes are fixed to a flat model: base 0 and a 4 GB limit.

An enter command switches the model to privilege level 0. The stack selector becomes one descriptor above the code selector, and the instruction and stack pointers come from the entry registers. An exit command switches to privilege level 3. Its selectors sit two and three descriptors above the configured one, and the pointers come from the EDX and ECX operands that the caller supplies. A constant flag tells software that the fast path exists. If the configured selector is zero, the command faults and leaves the state unchanged.

Top module: `fsc_unit`

## Requirements
- R1: After reset, all three configuration registers read as zero. cs_sel_o, ss_sel_o, cpl_o, eip_o and esp_o are all zero, and done_o and fault_o are low.
- R2: A write with msr_wr_i loads {msr_wdata_hi_i, msr_wdata_lo_i} into the register chosen by msr_idx_i. A read returns bits 63:32 on msr_rdata_hi_o and bits 31:0 on msr_rdata_lo_o, combinationally. Index 174h is the code selector, whose bits 15:0 are used. Index 175h is the entry stack pointer and 176h the entry instruction pointer; bits 31:0 of each are used.
- R3: A read of any other index returns zero on both data outputs and raises msr_rd_err_o. A read of an implemented index keeps msr_rd_err_o low. A write to any other index changes no register.
- R4: On enter, cs_sel_o becomes the configured selector and ss_sel_o becomes that selector plus 8, both modulo 2^16. cpl_o becomes 0, both bases become 0 and both limits become FFFFFFFFh.
- R5: On enter, eip_o takes the entry instruction pointer register and esp_o takes the entry stack pointer register.
- R6: On exit, cs_sel_o becomes the selector plus 16 and ss_sel_o becomes the selector plus 24, both modulo 2^16. cpl_o becomes 3, the segments are flat, eip_o takes gpr_edx_i and esp_o takes gpr_ecx_i.
- R7: An enter or exit with a zero configured selector pulses fault_o for one cycle. done_o stays low and every architectural output keeps its value.
- R8: A successful enter or exit updates the outputs at the next rising clock edge and raises done_o for exactly that one cycle.
- R9: An MSR write in the same cycle as enter or exit is not seen by that operation. It applies to later operations only.
- R10: If enter_i and exit_i are high together, the enter is performed.
- R11: sep_o is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msr_wr_i | input | 1 | MSR write strobe |
| msr_rd_i | input | 1 | MSR read strobe |
| msr_idx_i | input | 32 | MSR index (ECX) |
| msr_wdata_lo_i | input | 32 | Write data low half (EAX) |
| msr_wdata_hi_i | input | 32 | Write data high half (EDX) |
| msr_rdata_lo_o | output | 32 | Read data low half (EAX) |
| msr_rdata_hi_o | output | 32 | Read data high half (EDX) |
| msr_rd_err_o | output | 1 | Read of an unimplemented index |
| enter_i | input | 1 | Fast kernel-entry command |
| exit_i | input | 1 | Fast return command |
| gpr_edx_i | input | 32 | Return instruction pointer for exit |
| gpr_ecx_i | input | 32 | Return stack pointer for exit |
| cs_sel_o | output | 16 | Visible code selector |
| ss_sel_o | output | 16 | Visible stack selector |
| cs_base_o | output | 32 | Hidden code segment base |
| cs_limit_o | output | 32 | Hidden code segment limit |
| ss_base_o | output | 32 | Hidden stack segment base |
| ss_limit_o | output | 32 | Hidden stack segment limit |
| cpl_o | output | 2 | Current privilege level |
| eip_o | output | 32 | Instruction pointer |
| esp_o | output | 32 | Stack pointer |
| done_o | output | 1 | Operation completed (one-cycle pulse) |
| fault_o | output | 1 | Operation refused (one-cycle pulse) |
| sep_o | output | 1 | Fast path present |

## Verification
An MSR read is combinational, so its data and error flag are checked in the same low clock phase in which the read is driven. Enter, exit, fault and MSR writes all take effect at the first rising edge after they are driven on a falling edge. Every state, done_o and fault_o check is therefore sampled at the next falling edge, half a cycle after that rising edge. One further falling edge confirms that done_o has dropped. A write in the same cycle as an operation is checked at two points: in the result of that operation, and again in the result of the following one.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int SEL_W       = 16;
  localparam int SEG_W       = 32;
  localparam int DESC_STRIDE = 8;
  localparam logic [1:0] CPL_KERNEL = 2'd0;
  localparam logic [1:0] CPL_USER   = 2'd3;
  localparam logic [SEG_W-1:0] FLAT_BASE  = '0;
  localparam logic [SEG_W-1:0] FLAT_LIMIT = '1;

  typedef enum logic [1:0] {OP_NONE, OP_ENTER, OP_EXIT} op_e;

  typedef struct packed {
    logic [SEL_W-1:0] cs_sel;
    logic [SEL_W-1:0] ss_sel;
    logic [SEG_W-1:0] base;
    logic [SEG_W-1:0] limit;
    logic [1:0]       cpl;
  } seg_state_t;
endpackage

// File: rtl/fsc_msr_file.sv
module fsc_msr_file #(
  parameter int IDX_W    = 32,
  parameter int MSR_W    = 64,
  parameter int ADDR_W   = 32,
  parameter int NUM_MSR  = 3,
  parameter logic [IDX_W-1:0] BASE_IDX = 'h174
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [MSR_W-1:0]         wdata_i,
  output logic [MSR_W-1:0]         rdata_o,
  output logic                     rd_err_o,
  output logic [fsc_pkg::SEL_W-1:0] cfg_sel_o,
  output logic [ADDR_W-1:0]        cfg_esp_o,
  output logic [ADDR_W-1:0]        cfg_eip_o
);
  // slot order: 0 = code selector, 1 = entry stack, 2 = entry ip
  logic [MSR_W-1:0]   regs_q [NUM_MSR];
  logic [NUM_MSR-1:0] hit;

  for (genvar i = 0; i < NUM_MSR; i++) begin : g_slot
    assign hit[i] = (idx_i == BASE_IDX + IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          regs_q[i] <= '0;
      else if (wr_i && hit[i]) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_MSR; i++)
      if (hit[i]) rdata_o = regs_q[i];
  end

  assign rd_err_o  = rd_i && (hit == '0);
  assign cfg_sel_o = regs_q[0][fsc_pkg::SEL_W-1:0];
  assign cfg_esp_o = regs_q[1][ADDR_W-1:0];
  assign cfg_eip_o = regs_q[2][ADDR_W-1:0];
endmodule

// File: rtl/fsc_seg_gen.sv
module fsc_seg_gen
  import fsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  op_e               op_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] ent_eip_i,
  input  logic [ADDR_W-1:0] ent_esp_i,
  input  logic [ADDR_W-1:0] ret_eip_i,
  input  logic [ADDR_W-1:0] ret_esp_i,
  output seg_state_t        seg_o,
  output logic [ADDR_W-1:0] eip_o,
  output logic [ADDR_W-1:0] esp_o
);
  localparam logic [SEL_W-1:0] STEP1 = SEL_W'(DESC_STRIDE);
  localparam logic [SEL_W-1:0] STEP2 = SEL_W'(2 * DESC_STRIDE);
  localparam logic [SEL_W-1:0] STEP3 = SEL_W'(3 * DESC_STRIDE);

  always_comb begin
    seg_o.base  = FLAT_BASE;
    seg_o.limit = FLAT_LIMIT;
    if (op_i == OP_EXIT) begin
      seg_o.cs_sel = sel_i + STEP2;
      seg_o.ss_sel = sel_i + STEP3;
      seg_o.cpl    = CPL_USER;
      eip_o        = ret_eip_i;
      esp_o        = ret_esp_i;
    end else begin
      seg_o.cs_sel = sel_i;
      seg_o.ss_sel = sel_i + STEP1;
      seg_o.cpl    = CPL_KERNEL;
      eip_o        = ent_eip_i;
      esp_o        = ent_esp_i;
    end
  end
endmodule

// File: rtl/fsc_unit.sv
module fsc_unit
  import fsc_pkg::*;
#(
  parameter int IDX_W  = 32,
  parameter int ADDR_W = 32,
  parameter logic [IDX_W-1:0] MSR_BASE_IDX = 'h174
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msr_wr_i,
  input  logic              msr_rd_i,
  input  logic [IDX_W-1:0]  msr_idx_i,
  input  logic [31:0]       msr_wdata_lo_i,
  input  logic [31:0]       msr_wdata_hi_i,
  output logic [31:0]       msr_rdata_lo_o,
  output logic [31:0]       msr_rdata_hi_o,
  output logic              msr_rd_err_o,
  input  logic              enter_i,
  input  logic              exit_i,
  input  logic [ADDR_W-1:0] gpr_edx_i,
  input  logic [ADDR_W-1:0] gpr_ecx_i,
  output logic [SEL_W-1:0]  cs_sel_o,
  output logic [SEL_W-1:0]  ss_sel_o,
  output logic [SEG_W-1:0]  cs_base_o,
  output logic [SEG_W-1:0]  cs_limit_o,
  output logic [SEG_W-1:0]  ss_base_o,
  output logic [SEG_W-1:0]  ss_limit_o,
  output logic [1:0]        cpl_o,
  output logic [ADDR_W-1:0] eip_o,
  output logic [ADDR_W-1:0] esp_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              sep_o
);
  localparam int MSR_W   = 64;
  localparam int NUM_MSR = 3;

  logic [MSR_W-1:0]  rdata;
  logic [SEL_W-1:0]  cfg_sel;
  logic [ADDR_W-1:0] cfg_esp, cfg_eip;
  op_e               op;
  logic              bad_cfg, go;
  seg_state_t        seg_d, seg_q;
  logic [ADDR_W-1:0] eip_d, esp_d, eip_q, esp_q;
  logic              done_q, fault_q;

  fsc_msr_file #(
    .IDX_W(IDX_W), .MSR_W(MSR_W), .ADDR_W(ADDR_W),
    .NUM_MSR(NUM_MSR), .BASE_IDX(MSR_BASE_IDX)
  ) u_msr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (msr_wr_i),
    .rd_i     (msr_rd_i),
    .idx_i    (msr_idx_i),
    .wdata_i  ({msr_wdata_hi_i, msr_wdata_lo_i}),
    .rdata_o  (rdata),
    .rd_err_o (msr_rd_err_o),
    .cfg_sel_o(cfg_sel),
    .cfg_esp_o(cfg_esp),
    .cfg_eip_o(cfg_eip)
  );

  // enter wins a collision with exit
  always_comb begin
    if (enter_i)     op = OP_ENTER;
    else if (exit_i) op = OP_EXIT;
    else             op = OP_NONE;
  end

  assign bad_cfg = (op != OP_NONE) && (cfg_sel == '0);
  assign go      = (op != OP_NONE) && !bad_cfg;

  fsc_seg_gen #(.ADDR_W(ADDR_W)) u_seg (
    .op_i     (op),
    .sel_i    (cfg_sel),
    .ent_eip_i(cfg_eip),
    .ent_esp_i(cfg_esp),
    .ret_eip_i(gpr_edx_i),
    .ret_esp_i(gpr_ecx_i),
    .seg_o    (seg_d),
    .eip_o    (eip_d),
    .esp_o    (esp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '0;
      eip_q   <= '0;
      esp_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= go;
      fault_q <= bad_cfg;
      if (go) begin
        seg_q <= seg_d;
        eip_q <= eip_d;
        esp_q <= esp_d;
      end
    end
  end

  assign msr_rdata_lo_o = rdata[31:0];
  assign msr_rdata_hi_o = rdata[63:32];
  assign cs_sel_o   = seg_q.cs_sel;
  assign ss_sel_o   = seg_q.ss_sel;
  assign cs_base_o  = seg_q.base;
  assign ss_base_o  = seg_q.base;
  assign cs_limit_o = seg_q.limit;
  assign ss_limit_o = seg_q.limit;
  assign cpl_o      = seg_q.cpl;
  assign eip_o      = eip_q;
  assign esp_o      = esp_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign sep_o      = 1'b1;
endmodule

// File: rtl/fsc_unit_chk.sv
module fsc_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enter_i,
  input logic              exit_i,
  input logic [ADDR_W-1:0] gpr_edx_i,
  input logic [ADDR_W-1:0] gpr_ecx_i,
  input logic [31:0]       msr_rdata_lo_o,
  input logic [31:0]       msr_rdata_hi_o,
  input logic              msr_rd_err_o,
  input logic [15:0]       cs_sel_o,
  input logic [15:0]       ss_sel_o,
  input logic [31:0]       cs_base_o,
  input logic [1:0]        cpl_o,
  input logic [ADDR_W-1:0] eip_o,
  input logic [ADDR_W-1:0] esp_o,
  input logic              done_o,
  input logic              fault_o
);
  assert_err_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_rd_err_o |-> (msr_rdata_lo_o == '0 && msr_rdata_hi_o == '0));

  assert_enter_ss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cpl_o == 2'd0) |-> (ss_sel_o == cs_sel_o + 16'd8 && cs_base_o == '0));

  assert_exit_regs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(!enter_i)) |->
      (eip_o == $past(gpr_edx_i) && esp_o == $past(gpr_ecx_i) && cpl_o == 2'd3));

  assert_fault_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cs_sel_o == $past(cs_sel_o) && eip_o == $past(eip_o) && cpl_o == $past(cpl_o)));

  assert_fault_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && done_o));

  assert_done_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> $past(enter_i || exit_i));

  assert_enter_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(enter_i)) |-> cpl_o == 2'd0);
endmodule

bind fsc_unit fsc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enter_i(enter_i), .exit_i(exit_i),
  .gpr_edx_i(gpr_edx_i), .gpr_ecx_i(gpr_ecx_i),
  .msr_rdata_lo_o(msr_rdata_lo_o), .msr_rdata_hi_o(msr_rdata_hi_o),
  .msr_rd_err_o(msr_rd_err_o), .cs_sel_o(cs_sel_o), .ss_sel_o(ss_sel_o),
  .cs_base_o(cs_base_o), .cpl_o(cpl_o), .eip_o(eip_o), .esp_o(esp_o),
  .done_o(done_o), .fault_o(fault_o)
);

// File: tb/fsc_unit_tb.sv
module fsc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msr_wr = 0, msr_rd = 0, enter = 0, exit_c = 0;
  logic [31:0] msr_idx = 0, wlo = 0, whi = 0, edx = 0, ecx = 0;
  logic [31:0] rlo, rhi, cs_base, cs_limit, ss_base, ss_limit, eip, esp;
  logic [15:0] cs_sel, ss_sel;
  logic [1:0]  cpl;
  logic        rd_err, done, fault, sep;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fsc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .msr_wr_i(msr_wr), .msr_rd_i(msr_rd),
    .msr_idx_i(msr_idx), .msr_wdata_lo_i(wlo), .msr_wdata_hi_i(whi),
    .msr_rdata_lo_o(rlo), .msr_rdata_hi_o(rhi), .msr_rd_err_o(rd_err),
    .enter_i(enter), .exit_i(exit_c), .gpr_edx_i(edx), .gpr_ecx_i(ecx),
    .cs_sel_o(cs_sel), .ss_sel_o(ss_sel), .cs_base_o(cs_base), .cs_limit_o(cs_limit),
    .ss_base_o(ss_base), .ss_limit_o(ss_limit), .cpl_o(cpl), .eip_o(eip), .esp_o(esp),
    .done_o(done), .fault_o(fault), .sep_o(sep)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, results visible at following negedge
  task automatic step(bit wr, logic [31:0] idx, logic [31:0] hi, logic [31:0] lo,
                      bit en, bit ex, logic [31:0] d, logic [31:0] c);
    @(negedge clk);
    msr_wr = wr; msr_idx = idx; whi = hi; wlo = lo;
    enter = en; exit_c = ex; edx = d; ecx = c;
    @(negedge clk);
    msr_wr = 0; enter = 0; exit_c = 0;
  endtask

  task automatic rd(string tag, logic [31:0] idx, logic [31:0] ehi, logic [31:0] elo, bit eerr);
    @(negedge clk);
    msr_rd = 1; msr_idx = idx;
    #2;
    chk({tag, " rd_hi"}, rhi, ehi);
    chk({tag, " rd_lo"}, rlo, elo);
    chk({tag, " rd_err"}, rd_err, eerr);
    msr_rd = 0;
  endtask

  task automatic state(string tag, logic [15:0] c, logic [15:0] s, logic [1:0] p,
                       logic [31:0] ip, logic [31:0] sp);
    chk({tag, " cs"}, cs_sel, c);
    chk({tag, " ss"}, ss_sel, s);
    chk({tag, " cpl"}, cpl, p);
    chk({tag, " eip"}, eip, ip);
    chk({tag, " esp"}, esp, sp);
  endtask

  task automatic t_reset();
    state("R1 reset", 16'h0, 16'h0, 2'd0, 32'h0, 32'h0);
    chk("R1 done", done, 0);
    chk("R1 fault", fault, 0);
    chk("R11 sep", sep, 1);
    rd("R1 sel", 32'h174, 0, 0, 0);
    rd("R1 esp", 32'h175, 0, 0, 0);
    rd("R1 eip", 32'h176, 0, 0, 0);
  endtask

  task automatic t_fault_unconfigured();
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 fault", fault, 1);
    chk("R7 no done", done, 0);
    state("R7 unchanged", 16'h0, 16'h0, 2'd0, 32'h0, 32'h0);
    @(negedge clk);
    chk("R7 fault one cycle", fault, 0);
  endtask

  task automatic t_msr();
    step(1, 32'h174, 32'h1234_5678, 32'hABCD_0008, 0, 0, 0, 0);
    step(1, 32'h175, 32'h0000_0001, 32'h8000_F000, 0, 0, 0, 0);
    step(1, 32'h176, 32'hDEAD_BEEF, 32'h8040_1000, 0, 0, 0, 0);
    rd("R2 sel", 32'h174, 32'h1234_5678, 32'hABCD_0008, 0);
    rd("R2 esp", 32'h175, 32'h0000_0001, 32'h8000_F000, 0);
    rd("R2 eip", 32'h176, 32'hDEAD_BEEF, 32'h8040_1000, 0);
  endtask

  task automatic t_unimpl();
    rd("R3 unimpl 177", 32'h177, 0, 0, 1);
    rd("R3 unimpl 173", 32'h173, 0, 0, 1);
    step(1, 32'h200, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(1, 32'h1174, 32'h5555_5555, 32'h5555_5555, 0, 0, 0, 0);
    rd("R3 ignored sel", 32'h174, 32'h1234_5678, 32'hABCD_0008, 0);
    rd("R3 ignored esp", 32'h175, 32'h0000_0001, 32'h8000_F000, 0);
    rd("R3 ignored eip", 32'h176, 32'hDEAD_BEEF, 32'h8040_1000, 0);
  endtask

  task automatic t_enter();
    step(0, 0, 0, 0, 1, 0, 32'h1111, 32'h2222);
    chk("R8 done", done, 1);
    chk("R8 no fault", fault, 0);
    state("R4 R5 enter", 16'h0008, 16'h0010, 2'd0, 32'h8040_1000, 32'h8000_F000);
    chk("R4 cs base", cs_base, 0);
    chk("R4 cs limit", cs_limit, 32'hFFFF_FFFF);
    chk("R4 ss base", ss_base, 0);
    chk("R4 ss limit", ss_limit, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
  endtask

  task automatic t_exit();
    step(0, 0, 0, 0, 0, 1, 32'h0040_2345, 32'h0012_FF80);
    chk("R8 exit done", done, 1);
    state("R6 exit", 16'h0018, 16'h0020, 2'd3, 32'h0040_2345, 32'h0012_FF80);
    chk("R6 cs limit", cs_limit, 32'hFFFF_FFFF);
    chk("R6 ss base", ss_base, 0);
  endtask

  task automatic t_same_cycle_write();
    step(1, 32'h174, 0, 32'h0000_0060, 1, 0, 0, 0);
    state("R9 old sel", 16'h0008, 16'h0010, 2'd0, 32'h8040_1000, 32'h8000_F000);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 new sel cs", cs_sel, 16'h0060);
    chk("R9 new sel ss", ss_sel, 16'h0068);
    step(1, 32'h176, 0, 32'h0000_7777, 0, 1, 32'hAAAA_0000, 32'hBBBB_0000);
    state("R9 exit with write", 16'h0070, 16'h0078, 2'd3, 32'hAAAA_0000, 32'hBBBB_0000);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R9 later eip", eip, 32'h0000_7777);
  endtask

  task automatic t_both();
    step(0, 0, 0, 0, 1, 1, 32'hCAFE_0000, 32'hCAFE_1111);
    chk("R10 done", done, 1);
    state("R10 enter wins", 16'h0060, 16'h0068, 2'd0, 32'h0000_7777, 32'h8000_F000);
  endtask

  task automatic t_wrap();
    step(1, 32'h174, 0, 32'h0000_FFF8, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 32'h10, 32'h20);
    chk("R6 wrap cs", cs_sel, 16'h0008);
    chk("R6 wrap ss", ss_sel, 16'h0010);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 wrap ss", ss_sel, 16'h0000);
    chk("R4 wrap cs", cs_sel, 16'hFFF8);
  endtask

  task automatic t_fault_after_config();
    step(1, 32'h174, 32'hFFFF_0000, 32'h0000_0000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 32'h99, 32'h88);
    chk("R7 exit fault", fault, 1);
    chk("R7 exit no done", done, 0);
    state("R7 held", 16'hFFF8, 16'h0000, 2'd0, 32'h0000_7777, 32'h8000_F000);
    chk("R11 sep later", sep, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_fault_unconfigured();
    t_msr();
    t_unimpl();
    t_enter();
    t_exit();
    t_same_cycle_write();
    t_both();
    t_wrap();
    t_fault_after_config();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule